// File: doc/BRIEF.md
# Recursive Temporal Smoother and Derivative

This block filters a stream of spatially smoothed 8-bit pixels along time. For every pixel it delivers two 12-bit signed values: an intensity smoothed over space and time, and an estimate of its temporal derivative. Long multi-frame kernels are replaced by a cascade of three first-order recursive low-pass stages, each updated with shifts and adds only. The derivative is the difference between the first and second stage outputs. Each pixel position therefore needs only three stage values, one frame's worth of state per stage. This accepts slightly lower accuracy than a long window in exchange for a much smaller store.

The stage values live in an external frame-sized memory. For each pixel the block reads the word at the pixel's raster address, applies the recursion, writes the updated word back, and presents the result. Pixels enter on a valid/ready interface and results leave on one. Only one pixel is in flight: `in_ready` is high only while the block is empty. A result stays on the outputs, unchanged, until `out_ready` takes it. The memory must take a read or write request in the cycle it is raised. A read must return exactly one `st_rsp_valid` pulse, in order, at least one cycle later.

A frame-start flag sent with a pixel resets the raster address. When the flag comes with `seed_en` high, the whole frame seeds the state from the incoming pixels instead of reading memory. After reset the block also seeds until the next frame start.

Top module: `tempo_iir_filter`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid`, `st_rd_valid` and `st_wr_valid` are 0.
- R2: Once a pixel is accepted, `in_ready` stays 0 until its result is taken. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_smooth` and `out_deriv` hold their values. The cycle after the result is taken, `out_valid` is 0.
- R3: A pixel seeds when it carries `in_sof`=1 with `seed_en`=1. It also seeds when it carries `in_sof`=0 and the most recent frame start was a seeding one, or when no frame start has come since reset. `seed_en` is ignored on pixels with `in_sof`=0. A seeded pixel issues no read. Its result and write appear one cycle after acceptance, with every stage equal to pix*2^FRAC and `out_deriv`=0.
- R4: A pixel with `in_sof`=1 uses address 0. Each later pixel uses the previous address plus one, wrapping from NPIX-1 to 0.
- R5: The state word holds stage 1 in bits [SW-1:0], stage 2 in [2SW-1:SW] and stage 3 in [3SW-1:2SW], with SW=PIX_W+FRAC. For input x=pix*2^FRAC, stage 1 is updated as s1+((x-s1)>>>K). Stage n+1 is updated the same way with the new stage n value as its target, using an arithmetic shift.
- R6: `out_smooth` equals the new stage 3 value shifted right by FRAC-OFRAC. `out_deriv` equals the new stage 1 value minus the new stage 2 value, arithmetic-shifted right by FRAC-OFRAC, then multiplied by 2^DGAIN.
- R7: A pixel that does not seed issues one read pulse at its address. Its result and a one-cycle write pulse appear one cycle after `st_rsp_valid`. The write carries the same address and the updated state word.
- R8: Both outputs saturate to the signed OUT_W range, from -2^(OUT_W-1) to 2^(OUT_W-1)-1, instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_en | input | 1 | Seed the frame begun by the current frame-start pixel |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_pix | input | PIX_W | Spatially smoothed pixel |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_smooth | output | OUT_W | Space-time smoothed intensity, signed |
| out_deriv | output | OUT_W | Temporal derivative, signed |
| st_rd_valid | output | 1 | State read request pulse |
| st_rd_addr | output | AW | State read address |
| st_rsp_valid | input | 1 | State read data valid |
| st_rsp_data | input | 3*SW | State read data |
| st_wr_valid | output | 1 | State write pulse |
| st_wr_addr | output | AW | State write address |
| st_wr_data | output | 3*SW | Updated state word |

## Verification
The bench builds the block with K=1, DGAIN=3 and NPIX=4, and uses the default 8-bit pixels with FRAC=4 and OFRAC=3. The fast coefficient and large derivative gain let a single full-scale step drive the derivative into both saturation limits. The four-pixel frame lets address wrap, a mid-frame frame start and a re-seed all occur within a few dozen pixels. A memory model with a two-cycle read latency exercises the wait between request and response.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int TIF_STAGES = 3;

  typedef enum logic [1:0] {
    TIF_IDLE = 2'd0,
    TIF_WAIT = 2'd1,
    TIF_OUT  = 2'd2
  } tif_state_e;
endpackage

// File: rtl/tif_stage.sv
module tif_stage #(
  parameter int SW = 12,
  parameter int K  = 2
) (
  input  logic [SW-1:0] target,
  input  logic [SW-1:0] cur,
  output logic [SW-1:0] nxt
);
  logic signed [SW:0] diff, step, sum;

  always_comb begin
    diff = $signed({1'b0, target}) - $signed({1'b0, cur});
    step = diff >>> K;
    sum  = $signed({1'b0, cur}) + step;
    nxt  = sum[SW-1:0];
  end
endmodule

// File: rtl/tif_sat.sv
module tif_sat #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic signed [IN_W-1:0]  v,
  output logic signed [OUT_W-1:0] y
);
  localparam logic signed [IN_W-1:0] MAXV =
    signed'({{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
  localparam logic signed [IN_W-1:0] MINV = ~MAXV;

  always_comb begin
    if (v > MAXV)      y = MAXV[OUT_W-1:0];
    else if (v < MINV) y = MINV[OUT_W-1:0];
    else               y = v[OUT_W-1:0];
  end
endmodule

// File: rtl/tif_recursion.sv
module tif_recursion import tif_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int FRAC  = 4,
  parameter int OFRAC = 3,
  parameter int K     = 2,
  parameter int DGAIN = 0,
  parameter int OUT_W = 12
) (
  input  logic [PIX_W+FRAC-1:0]            x,
  input  logic [TIF_STAGES*(PIX_W+FRAC)-1:0] prev,
  output logic [TIF_STAGES*(PIX_W+FRAC)-1:0] next,
  output logic signed [OUT_W-1:0]          smooth,
  output logic signed [OUT_W-1:0]          deriv
);
  localparam int SW   = PIX_W + FRAC;
  localparam int WIDE = SW + 2 + DGAIN;
  localparam int OSH  = FRAC - OFRAC;

  logic [SW-1:0] nx [TIF_STAGES];

  for (genvar g = 0; g < TIF_STAGES; g++) begin : g_stage
    logic [SW-1:0] tgt;
    if (g == 0) begin : g_head
      assign tgt = x;
    end else begin : g_tail
      assign tgt = nx[g-1];
    end
    tif_stage #(.SW(SW), .K(K)) u_stage (
      .target (tgt),
      .cur    (prev[g*SW +: SW]),
      .nxt    (nx[g])
    );
    assign next[g*SW +: SW] = nx[g];
  end

  logic signed [SW:0]     d_raw, d_sh;
  logic signed [WIDE-1:0] d_wide, s_wide;

  always_comb begin
    d_raw  = $signed({1'b0, nx[0]}) - $signed({1'b0, nx[1]});
    d_sh   = d_raw >>> OSH;
    d_wide = {{(WIDE-SW-1){d_sh[SW]}}, d_sh} <<< DGAIN;
    s_wide = signed'({{(WIDE-SW){1'b0}}, nx[TIF_STAGES-1]} >> OSH);
  end

  tif_sat #(.IN_W(WIDE), .OUT_W(OUT_W)) u_sat_d (.v(d_wide), .y(deriv));
  tif_sat #(.IN_W(WIDE), .OUT_W(OUT_W)) u_sat_s (.v(s_wide), .y(smooth));
endmodule

// File: rtl/tif_raster_addr.sv
module tif_raster_addr #(
  parameter int NPIX = 76800,
  parameter int AW   = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          sof,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:0] cnt_q;

  assign cur_addr = sof ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (step)
      cnt_q <= ({1'b0, cur_addr} == (AW+1)'(NPIX-1)) ? '0 : cur_addr + 1'b1;
  end
endmodule

// File: rtl/tempo_iir_filter.sv
module tempo_iir_filter import tif_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int OUT_W = 12,
  parameter int FRAC  = 4,
  parameter int OFRAC = 3,
  parameter int K     = 2,
  parameter int DGAIN = 0,
  parameter int NPIX  = 76800,
  localparam int SW   = PIX_W + FRAC,
  localparam int WW   = TIF_STAGES * SW,
  localparam int AW   = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seed_en,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sof,
  input  logic [PIX_W-1:0]        in_pix,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_smooth,
  output logic signed [OUT_W-1:0] out_deriv,
  output logic                    st_rd_valid,
  output logic [AW-1:0]           st_rd_addr,
  input  logic                    st_rsp_valid,
  input  logic [WW-1:0]           st_rsp_data,
  output logic                    st_wr_valid,
  output logic [AW-1:0]           st_wr_addr,
  output logic [WW-1:0]           st_wr_data
);
  tif_state_e         state_q;
  logic               seed_q;
  logic [PIX_W-1:0]   pix_q;
  logic [AW-1:0]      addr_q;
  logic [AW-1:0]      cur_addr;
  logic               accept, seed_now, commit;
  logic [SW-1:0]      rec_x;
  logic [WW-1:0]      rec_prev, rec_next;
  logic signed [OUT_W-1:0] rec_smooth, rec_deriv;

  assign in_ready  = (state_q == TIF_IDLE);
  assign out_valid = (state_q == TIF_OUT);
  assign accept    = in_valid && in_ready;
  assign seed_now  = in_sof ? seed_en : seed_q;
  assign commit    = (accept && seed_now) ||
                     ((state_q == TIF_WAIT) && st_rsp_valid);

  tif_raster_addr #(.NPIX(NPIX), .AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (accept),
    .sof      (in_sof),
    .cur_addr (cur_addr)
  );

  // Seeding feeds the pixel in as every previous stage: the recursion then leaves it unchanged.
  always_comb begin
    if (state_q == TIF_IDLE) begin
      rec_x    = {in_pix, {FRAC{1'b0}}};
      rec_prev = {TIF_STAGES{rec_x}};
    end else begin
      rec_x    = {pix_q, {FRAC{1'b0}}};
      rec_prev = st_rsp_data;
    end
  end

  tif_recursion #(
    .PIX_W(PIX_W), .FRAC(FRAC), .OFRAC(OFRAC),
    .K(K), .DGAIN(DGAIN), .OUT_W(OUT_W)
  ) u_rec (
    .x      (rec_x),
    .prev   (rec_prev),
    .next   (rec_next),
    .smooth (rec_smooth),
    .deriv  (rec_deriv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= TIF_IDLE;
      seed_q      <= 1'b1;
      pix_q       <= '0;
      addr_q      <= '0;
      st_rd_valid <= 1'b0;
      st_rd_addr  <= '0;
      st_wr_valid <= 1'b0;
      st_wr_addr  <= '0;
      st_wr_data  <= '0;
      out_smooth  <= '0;
      out_deriv   <= '0;
    end else begin
      st_rd_valid <= 1'b0;
      st_wr_valid <= 1'b0;
      if (commit) begin
        out_smooth  <= rec_smooth;
        out_deriv   <= rec_deriv;
        st_wr_valid <= 1'b1;
        st_wr_data  <= rec_next;
        st_wr_addr  <= (state_q == TIF_IDLE) ? cur_addr : addr_q;
      end
      case (state_q)
        TIF_IDLE: if (accept) begin
          pix_q  <= in_pix;
          addr_q <= cur_addr;
          if (in_sof) seed_q <= seed_en;
          if (seed_now) begin
            state_q <= TIF_OUT;
          end else begin
            st_rd_valid <= 1'b1;
            st_rd_addr  <= cur_addr;
            state_q     <= TIF_WAIT;
          end
        end
        TIF_WAIT: if (st_rsp_valid) state_q <= TIF_OUT;
        TIF_OUT:  if (out_ready)    state_q <= TIF_IDLE;
        default:  state_q <= TIF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tempo_iir_filter_chk.sv
module tempo_iir_filter_chk #(
  parameter int OUT_W = 12,
  parameter int AW    = 17,
  parameter int NPIX  = 76800
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    seed_en,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_sof,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_smooth,
  input logic signed [OUT_W-1:0] out_deriv,
  input logic                    st_rd_valid,
  input logic [AW-1:0]           st_rd_addr,
  input logic                    st_rsp_valid,
  input logic                    st_wr_valid
);
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_smooth) && $stable(out_deriv))); // R2

  AST_SEED_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof && seed_en) |=> (!st_rd_valid && out_valid && st_wr_valid)); // R3

  AST_SOF_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof && !seed_en) |=> (st_rd_valid && st_rd_addr == '0)); // R4

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd_valid |-> ({1'b0, st_rd_addr} < (AW+1)'(NPIX))); // R4

  AST_RSP_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rsp_valid && !out_valid) |=> (out_valid && st_wr_valid)); // R7

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_valid |=> !st_wr_valid); // R7
endmodule

bind tempo_iir_filter tempo_iir_filter_chk #(.OUT_W(OUT_W), .AW(AW), .NPIX(NPIX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .seed_en      (seed_en),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_sof       (in_sof),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_smooth   (out_smooth),
  .out_deriv    (out_deriv),
  .st_rd_valid  (st_rd_valid),
  .st_rd_addr   (st_rd_addr),
  .st_rsp_valid (st_rsp_valid),
  .st_wr_valid  (st_wr_valid)
);

// File: tb/tempo_iir_filter_tb.sv
module tempo_iir_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8, OUT_W = 12, FRAC = 4, OFRAC = 3;
  localparam int K = 1, DGAIN = 3, NPIX = 4, AW = 2;
  localparam int SW = PIX_W + FRAC, WW = 3 * SW;
  localparam int RD_LAT = 2;

  typedef struct packed { logic sof; logic seed; logic [7:0] pix; } vec_t;
  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 8'd0},   '{1'b0, 1'b0, 8'd255}, '{1'b0, 1'b0, 8'd100}, '{1'b0, 1'b1, 8'd10},
    '{1'b1, 1'b0, 8'd255}, '{1'b0, 1'b0, 8'd0},   '{1'b0, 1'b1, 8'd100}, '{1'b0, 1'b0, 8'd200},
    '{1'b0, 1'b0, 8'd255}, '{1'b0, 1'b0, 8'd0},   '{1'b0, 1'b0, 8'd77},  '{1'b1, 1'b0, 8'd13},
    '{1'b1, 1'b1, 8'd50},  '{1'b0, 1'b0, 8'd60},  '{1'b1, 1'b0, 8'd0},   '{1'b0, 1'b0, 8'd128}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic seed_en = 1'b0, in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
  logic [PIX_W-1:0] in_pix = '0;
  logic in_ready, out_valid, st_rd_valid, st_wr_valid;
  logic signed [OUT_W-1:0] out_smooth, out_deriv;
  logic [AW-1:0] st_rd_addr, st_wr_addr;
  logic [WW-1:0] st_wr_data;
  logic st_rsp_valid = 1'b0;
  logic [WW-1:0] st_rsp_data = '0;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tempo_iir_filter #(
    .PIX_W(PIX_W), .OUT_W(OUT_W), .FRAC(FRAC), .OFRAC(OFRAC),
    .K(K), .DGAIN(DGAIN), .NPIX(NPIX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .seed_en(seed_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_smooth(out_smooth), .out_deriv(out_deriv),
    .st_rd_valid(st_rd_valid), .st_rd_addr(st_rd_addr),
    .st_rsp_valid(st_rsp_valid), .st_rsp_data(st_rsp_data),
    .st_wr_valid(st_wr_valid), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data)
  );

  // State memory model with a fixed read latency.
  logic [WW-1:0] mem [NPIX];
  int pend_cnt = 0, rd_count = 0, last_rd_addr = 0;
  logic [AW-1:0] pend_addr = '0;
  always @(posedge clk) begin
    st_rsp_valid <= 1'b0;
    if (pend_cnt == 1) begin
      st_rsp_valid <= 1'b1;
      st_rsp_data  <= mem[pend_addr];
    end
    if (pend_cnt != 0) pend_cnt <= pend_cnt - 1;
    if (st_rd_valid) begin
      pend_cnt     <= RD_LAT;
      pend_addr    <= st_rd_addr;
      rd_count     <= rd_count + 1;
      last_rd_addr <= int'(st_rd_addr);
    end
    if (st_wr_valid) mem[st_wr_addr] <= st_wr_data;
  end

  // Reference model state.
  int ref_s [NPIX][3];
  int ref_cnt = 0;
  bit ref_seed = 1'b1;

  function automatic int sat(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Drive one pixel, collect its result and check it against the model.
  task automatic run_pix(input bit sof, input bit seed, input int pix, input int hold,
                         output int got_deriv);
    int addr, x, p1, p2, p3, s1, s2, s3, exp_sm, exp_dv, rd0, wait_n;
    bit sd;
    logic [WW-1:0] exp_word;
    logic signed [OUT_W-1:0] hold_sm, hold_dv;
    addr = sof ? 0 : ref_cnt;
    sd   = sof ? seed : ref_seed;
    if (sof) ref_seed = seed;
    ref_cnt = (addr == NPIX-1) ? 0 : addr + 1;
    x = pix * 16;
    if (sd) begin p1 = x; p2 = x; p3 = x; end
    else begin p1 = ref_s[addr][0]; p2 = ref_s[addr][1]; p3 = ref_s[addr][2]; end
    s1 = p1 + ((x - p1) >>> K);
    s2 = p2 + ((s1 - p2) >>> K);
    s3 = p3 + ((s2 - p3) >>> K);
    ref_s[addr][0] = s1; ref_s[addr][1] = s2; ref_s[addr][2] = s3;
    exp_sm   = sat(s3 >>> 1);
    exp_dv   = sat(((s1 - s2) >>> 1) * 8);
    exp_word = {12'(s3), 12'(s2), 12'(s1)};
    rd0 = rd_count;

    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; seed_en = seed; in_pix = 8'(pix);
    out_ready = (hold == 0);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; seed_en = 1'b0;
    wait_n = 0;
    if (sd) check(out_valid === 1'b1, "R3 seed result one cycle after accept", 64'(out_valid), 1);
    while (!out_valid && wait_n < 50) begin @(negedge clk); wait_n++; end
    check(out_valid === 1'b1, "R7 result appears", 64'(out_valid), 1);
    check(out_smooth === 12'(exp_sm), "R6 out_smooth", longint'(out_smooth), exp_sm);
    check(out_deriv === 12'(exp_dv), "R6/R8 out_deriv", longint'(out_deriv), exp_dv);
    check(st_wr_valid === 1'b1 && int'(st_wr_addr) == addr, "R7 write pulse and address",
          longint'(st_wr_addr), addr);
    check(st_wr_data === exp_word, "R5 written state word", longint'(st_wr_data), longint'(exp_word));
    if (sd) check(rd_count == rd0, "R3 seeded pixel issues no read", rd_count - rd0, 0);
    else begin
      check(rd_count == rd0 + 1, "R7 one read per pixel", rd_count - rd0, 1);
      check(last_rd_addr == addr, "R4 read address", last_rd_addr, addr);
    end
    got_deriv = int'(out_deriv);
    hold_sm = out_smooth; hold_dv = out_deriv;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(out_valid === 1'b1 && in_ready === 1'b0, "R2 held under back-pressure",
            64'(out_valid), 1);
      check(out_smooth === hold_sm && out_deriv === hold_dv, "R2 outputs stable",
            longint'(out_deriv), longint'(hold_dv));
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R2 result taken", 64'(out_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int dv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(in_ready === 1'b1, "R1 in_ready after reset", 64'(in_ready), 1);
    check(out_valid === 1'b0, "R1 out_valid after reset", 64'(out_valid), 0);
    check(st_rd_valid === 1'b0 && st_wr_valid === 1'b0, "R1 no memory traffic", 64'(st_rd_valid), 0);

    for (int i = 0; i < NVEC; i++) begin
      run_pix(VEC[i].sof, VEC[i].seed, int'(VEC[i].pix), 0, dv);
      // R8: hand-derived saturation points (step 0->255 and 255->0 with K=1, DGAIN=3)
      if (i == 4) check(dv == 2047, "R8 positive saturation", dv, 2047);
      if (i == 5) check(dv == -2048, "R8 negative saturation", dv, -2048);
    end

    // R2: back-pressure holds the result and blocks input
    run_pix(1'b0, 1'b0, 200, 3, dv);

    // R1/R3: reset mid-stream returns to seeding at address 0
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    ref_cnt = 0; ref_seed = 1'b1;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 idle after second reset", 64'(out_valid), 0);
    run_pix(1'b0, 1'b0, 90, 0, dv);
    check(dv == 0, "R3 seeded derivative is zero", dv, 0);
    run_pix(1'b0, 1'b0, 91, 1, dv);

    summary();
    $finish;
  end
endmodule